// File: doc/BRIEF.md
# Sector Write Load Controller

This block models, on a single synchronous clock, the byte-load phase of a nonvolatile memory that is programmed one 64-byte sector at a time. It decodes the active-low chip-enable, write-enable and output-enable lines into write strobes. It takes each strobe's byte address when the strobe begins and its data when the strobe ends, and places the byte in a sector buffer.

The first accepted strobe opens a load window and fixes the sector that the window belongs to. After each strobe ends, a counter measures idle time. When the counter reaches the limit without a new strobe, the window closes. The block then emits a one-cycle start pulse and holds a busy flag for a fixed program period. The full buffer image is presented for that whole period. Every byte that was not loaded in the window appears as FFh.

When the program period ends, the buffer returns to all FFh and the block is ready for the next sector. While busy, the block ignores strobes, and a read returns a fixed status code in place of buffer data.

Top module: `sector_load_ctrl`

## Requirements
- R1: After reset, busy, the start pulse and the sector error flag are low, and every byte of the buffer image is FFh.
- R2: A write strobe exists only while chip-enable and write-enable are both low and output-enable is high. Write-enable low with chip-enable high writes nothing. Output-enable low writes nothing.
- R3: The target byte is taken from the address present on the first cycle of the strobe. A later change of the address during the same strobe does not move the write.
- R4: The data written is the data input sampled on the first cycle in which the strobe condition is false. Earlier values during the strobe are discarded.
- R5: Address bits 5:0 select the byte, which is placed at image bits [8*offset+7 : 8*offset]. Address bits 14:6 select the sector. Bytes may arrive in any order, and a repeated offset keeps the last value written.
- R6: At the start of programming, every byte not loaded during the window reads FFh in the image.
- R7: Define E as the clock edge at which the end of the last strobe is seen. With a timeout limit of T cycles, busy and a one-cycle start pulse are both high after edge E+T and low before it. Any strobe that arrives earlier restarts the count.
- R8: Busy stays high for exactly PROG_CYC cycles. When it falls, the image is all FFh and the sector error flag is clear.
- R9: A strobe whose sector differs from the sector latched by the window's first strobe sets the sector error flag, and its byte is not written.
- R10: While busy, strobes change nothing, and a read (chip-enable and output-enable low, write-enable high) returns BUSY_CODE. While idle, a read returns the buffer byte at address bits 5:0. With no read in progress, the data output is 0.
- R11: The sector output carries address bits 14:6 of the window's first strobe during programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 15 | Byte address; bits 14:6 sector, 5:0 offset |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or busy status code |
| buf_image | output | 512 | Sector buffer image, byte n at bits 8n+7:8n |
| prog_sector | output | 9 | Sector latched for the current window |
| prog_start | output | 1 | One-cycle pulse when programming begins |
| busy | output | 1 | Program period in progress |
| sector_err | output | 1 | A strobe addressed a different sector |

## Verification
On every cycle, the assertions check four things: the image stays frozen while busy, the start pulse lasts one cycle and coincides with busy, the image is all FFh whenever busy falls, and programming never begins while a strobe is still active. Other behaviour can only be shown by the bench's scenarios. These are the exact cycle on which the timeout fires, its restart by a late strobe, the choice of address at strobe start and data at strobe end, the rejection of foreign-sector and inhibited strobes, and the length of the busy period.

// File: rtl/sector_load_ctrl.sv
module sector_load_ctrl #(
  parameter int CLK_MHZ   = 50,
  parameter int WINDOW_US = 150,
  parameter int PROG_CYC  = 500,
  parameter int ADDR_W    = 15,
  parameter int OFF_W     = 6,
  parameter int DATA_W    = 8,
  parameter logic [7:0] BUSY_CODE = 8'hB0
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  ce_n,
  input  logic                                  we_n,
  input  logic                                  oe_n,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [DATA_W-1:0]                     din,
  output logic [DATA_W-1:0]                     dout,
  output logic [(DATA_W<<OFF_W)-1:0]            buf_image,
  output logic [ADDR_W-OFF_W-1:0]               prog_sector,
  output logic                                  prog_start,
  output logic                                  busy,
  output logic                                  sector_err
);
  localparam int NBYTE   = 1 << OFF_W;
  localparam int SEC_W   = ADDR_W - OFF_W;
  localparam int TMO_CYC = CLK_MHZ * WINDOW_US;
  localparam int TW      = $clog2(TMO_CYC + 1);
  localparam int PW      = $clog2(PROG_CYC + 1);

  logic [DATA_W-1:0] mem [NBYTE];
  logic              strb_q, acc_q, win;
  logic [OFF_W-1:0]  off_q;
  logic [SEC_W-1:0]  sec_q;
  logic [TW-1:0]     tcnt;
  logic [PW-1:0]     pcnt;

  wire strb  = ~ce_n & ~we_n & oe_n;
  wire rd    = ~ce_n & ~oe_n & we_n;
  wire s_beg = strb & ~strb_q & ~busy;
  wire s_end = ~strb & strb_q;
  wire [SEC_W-1:0] sec_in = addr[ADDR_W-1:OFF_W];
  wire sec_ok = ~win | (sec_in == sec_q);
  wire tmo    = win & ~busy & ~strb & ~strb_q & (tcnt == TW'(TMO_CYC - 1));
  wire p_done = busy & (pcnt == PW'(PROG_CYC - 1));

  assign prog_sector = sec_q;
  assign dout = rd ? (busy ? DATA_W'(BUSY_CODE) : mem[addr[OFF_W-1:0]]) : '0;

  for (genvar g = 0; g < NBYTE; g++) begin : g_img
    assign buf_image[g*DATA_W +: DATA_W] = mem[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strb_q <= 1'b0;
      acc_q  <= 1'b0;
      off_q  <= '0;
    end else begin
      strb_q <= strb;
      if (s_beg) begin
        acc_q <= sec_ok;
        off_q <= addr[OFF_W-1:0];
      end else if (s_end || busy) begin
        acc_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win        <= 1'b0;
      sec_q      <= '0;
      sector_err <= 1'b0;
    end else begin
      if (s_beg && !win) begin
        win   <= 1'b1;
        sec_q <= sec_in;
      end else if (tmo) begin
        win <= 1'b0;
      end
      if (s_beg && !sec_ok) sector_err <= 1'b1;
      else if (p_done)      sector_err <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !win || strb || strb_q) tcnt <= '0;
    else if (tcnt != TW'(TMO_CYC - 1))   tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      prog_start <= 1'b0;
      pcnt       <= '0;
    end else begin
      prog_start <= tmo;
      if (tmo) begin
        busy <= 1'b1;
        pcnt <= '0;
      end else if (p_done) begin
        busy <= 1'b0;
      end else if (busy) begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || p_done) begin
      for (int i = 0; i < NBYTE; i++) mem[i] <= '1;
    end else if (s_end && acc_q && !busy) begin
      mem[off_q] <= din;
    end
  end

  p_frozen_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(buf_image));
  p_start_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);
  p_start_with_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> busy);
  p_clear_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (&buf_image && !sector_err));
  p_quiet_before_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(strb_q));
endmodule

// File: tb/sector_load_ctrl_bench.sv
`timescale 1ns/1ps
module sector_load_ctrl_bench;
  localparam int T = 20;
  localparam int P = 12;
  localparam logic [7:0] BC = 8'hB0;
  localparam logic [8:0] SEC = 9'h05A;
  localparam logic [13:0] VEC [8] = '{
    {6'd63, 8'h11}, {6'd0, 8'h22}, {6'd17, 8'h33}, {6'd5, 8'h00},
    {6'd40, 8'hC3}, {6'd17, 8'h44}, {6'd31, 8'h7E}, {6'd1, 8'hFF}};

  logic clk = 0, rst_n = 0, ce_n = 1, we_n = 1, oe_n = 1;
  logic [14:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic [511:0] buf_image;
  logic [8:0] prog_sector;
  logic prog_start, busy, sector_err;
  logic [7:0] exp_b [64];
  int checks = 0, errors = 0, bcnt = 0;

  always #10 clk = ~clk;

  sector_load_ctrl #(.CLK_MHZ(1), .WINDOW_US(T), .PROG_CYC(P), .BUSY_CODE(BC)) u_sector_load_ctrl (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
    .dout(dout), .buf_image(buf_image), .prog_sector(prog_sector), .prog_start(prog_start),
    .busy(busy), .sector_err(sector_err));

  always @(negedge clk) if (busy) bcnt <= bcnt + 1;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_img(string req);
    logic [511:0] e;
    for (int i = 0; i < 64; i++) e[i*8 +: 8] = exp_b[i];
    checks++;
    if (buf_image !== e) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, buf_image, e);
    end
  endtask

  task automatic wr(logic [14:0] a, logic [7:0] d);
    @(negedge clk); addr = a; din = d; oe_n = 1; ce_n = 0; we_n = 0;
    @(negedge clk); @(negedge clk);
    we_n = 1; ce_n = 1;
  endtask

  task automatic rd_chk(string req, logic [5:0] off, logic [7:0] exp);
    @(negedge clk); addr = {SEC, off}; we_n = 1; ce_n = 0; oe_n = 0; #1;
    chk(req, dout, exp);
    ce_n = 1; oe_n = 1;
  endtask

  task automatic wait_tmo(string req);
    repeat (T) @(negedge clk);
    chk(req, busy, 0);
    @(negedge clk);
    chk(req, {busy, prog_start}, 2'b11);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) exp_b[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 flags", {busy, prog_start, sector_err}, 0);
    chk_img("R1 image");
    chk("R10 idle dout", dout, 0);

    for (int v = 0; v < 8; v++) begin
      wr({SEC, VEC[v][13:8]}, VEC[v][7:0]);
      exp_b[VEC[v][13:8]] = VEC[v][7:0];
      rd_chk("R5 readback", VEC[v][13:8], VEC[v][7:0]);
      chk("R7 window open", busy, 0);
    end

    wr({SEC + 9'd1, 6'd2}, 8'h99);
    @(negedge clk);
    chk("R9 err", sector_err, 1);
    chk("R9 no write", buf_image[2*8 +: 8], 8'hFF);

    @(negedge clk); addr = {SEC, 6'd13}; din = 8'h66; ce_n = 0; we_n = 0; oe_n = 0;
    @(negedge clk); @(negedge clk); we_n = 1; ce_n = 1; oe_n = 1;
    @(negedge clk); addr = {SEC, 6'd14}; din = 8'h67; ce_n = 1; we_n = 0;
    @(negedge clk); @(negedge clk); we_n = 1;
    @(negedge clk);
    chk("R2 oe low", buf_image[13*8 +: 8], 8'hFF);
    chk("R2 ce high", buf_image[14*8 +: 8], 8'hFF);

    @(negedge clk); addr = {SEC, 6'd10}; din = 8'h5A; oe_n = 1; ce_n = 0; we_n = 0;
    @(negedge clk); addr = {SEC, 6'd11};
    @(negedge clk); we_n = 1; ce_n = 1;
    exp_b[10] = 8'h5A;
    @(negedge clk);
    chk("R3 start addr", buf_image[10*8 +: 8], 8'h5A);
    chk("R3 moved addr", buf_image[11*8 +: 8], 8'hFF);

    @(negedge clk); addr = {SEC, 6'd12}; din = 8'h01; oe_n = 1; ce_n = 0; we_n = 0;
    @(negedge clk); din = 8'hB7;
    @(negedge clk); we_n = 1; ce_n = 1;
    exp_b[12] = 8'hB7;
    wait_tmo("R7 timeout");
    chk_img("R6 fill");
    chk("R4 end data", buf_image[12*8 +: 8], 8'hB7);
    chk("R11 sector", prog_sector, SEC);
    @(negedge clk);
    chk("R7 pulse width", prog_start, 0);

    rd_chk("R10 busy code", 6'd63, BC);
    wr({SEC, 6'd0}, 8'h00);
    @(negedge clk);
    chk_img("R10 ignored");
    while (busy) @(negedge clk);
    chk("R8 length", bcnt, P);
    for (int i = 0; i < 64; i++) exp_b[i] = 8'hFF;
    chk_img("R8 cleared");
    chk("R8 err clear", sector_err, 0);
    rd_chk("R10 idle read", 6'd63, 8'hFF);

    bcnt = 0;
    wr({SEC, 6'd3}, 8'hA1);
    repeat (T - 2) @(negedge clk);
    chk("R7 restart", busy, 0);
    wr({SEC, 6'd4}, 8'hA2);
    exp_b[3] = 8'hA1; exp_b[4] = 8'hA2;
    wait_tmo("R7 restart tmo");
    chk_img("R5 second window");
    while (busy) @(negedge clk);
    chk("R8 length 2", bcnt, P);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule